// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block watches a bank of general-purpose input pins that have already been synchronized to the core clock. For each pin it decides whether an interrupt event has occurred, using that pin's configuration: level or edge sensing, the active polarity, and whether events latch at all. Each event is captured in a per-pin status flag. Software clears the flag by writing to it. The block then merges the flags into one summary interrupt line for each processor target.

Software reaches two registers per pin through a simple write strobe, an address and combinational read data. The configuration register holds the enable, the detection mode, the polarity, the latch (raw-status) enable and a 3-bit routing target. The status register returns the latched flag and the live pin level. A build option narrows the mode field to a single edge/level bit; in that option the polarity selects the edge direction.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every configuration register, every status flag and every summary output is 0.
- R2: Address bit 0 selects the register: 0 is configuration and 1 is status. The upper address bits select the pin. The configuration register has enable in bit 0, mode in bits 2:1, polarity in bit 3, latch enable in bit 4 and target in bits 7:5. It reads back the value that was written.
- R3: In mode 0 (level), a pin whose latch enable is set raises its status flag on the clock after its sampled input equals the polarity bit (1 = high active, 0 = low active).
- R4: Mode 1 latches rising edges, mode 2 latches falling edges and mode 3 latches both. Each edge is judged against the input sampled one clock earlier, and the flag is set on the clock after the input changes.
- R5: With the narrow mode option, configuration bit 2 always reads 0. Bit 1 set selects edge sensing, with polarity 1 for rising and 0 for falling. Bit 1 clear selects level sensing, as in R3.
- R6: A status flag stays set until a status write to its pin carries the acknowledge value in data bit 0 (1 by default, set by a parameter). A write that carries the other value leaves the flag unchanged.
- R7: When an event and an acknowledge fall in the same cycle, the flag stays set. An acknowledge therefore does not clear a level that is still active.
- R8: With the latch enable clear, no event sets the flag. Turning the latch enable on while the input is steady creates no event.
- R9: With the pin enable clear, the flag still latches but never raises a summary output.
- R10: Summary output t is a register that, one clock after the state it reflects, holds the OR of flag AND enable over all pins whose target is t.
- R11: A status read returns the flag in bit 0 and the current pin input in bit 1. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| we_i | input | 1 | Register write strobe |
| addr_i | input | SEL_W+1 | Register address: pin index above bit 0, register select in bit 0 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| irq_o | output | 8 | Registered summary interrupt, one bit per target |

## Verification
The hardest case to reach from the ports is a collision in one cycle between an acknowledge write and a fresh event on the same pin. A close second is a latch-enable change made while the input holds still, since only the absence of a flag shows the behaviour. Directed sequences set the pin level and the acknowledge write in the same low clock phase so that both land on one edge. They toggle the latch enable with the pin held high and then confirm through a status read that no flag appeared. A seeded random phase then mixes pin toggles with configuration and acknowledge writes to arbitrary pins. A bench model predicts every summary bit and status read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int TGT_W   = 3;
  localparam int NUM_TGT = 1 << TGT_W;
  localparam int CFG_W   = 5 + TGT_W;

  typedef struct packed {
    logic [TGT_W-1:0] target;
    logic             raw_en;
    logic             pol;
    logic [1:0]       mode;
    logic             en;
  } cfg_t;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_e;
endpackage

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
#(
  parameter int DET_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic cfg_we_i,
  input  cfg_t cfg_wdata_i,
  input  logic ack_i,
  output cfg_t cfg_o,
  output logic status_o
);
  logic pin_q, status_q;
  logic rise, fall, lvl, evt;
  cfg_t cfg_q, cfg_d;

  assign rise = pin_i & ~pin_q;
  assign fall = ~pin_i & pin_q;
  assign lvl  = ~(pin_i ^ cfg_q.pol);

  generate
    if (DET_W == 2) begin : g_wide
      always_comb begin
        case (det_e'(cfg_q.mode))
          DET_LEVEL: evt = lvl;
          DET_RISE:  evt = rise;
          DET_FALL:  evt = fall;
          default:   evt = rise | fall;
        endcase
      end
      always_comb cfg_d = cfg_wdata_i;
    end else begin : g_narrow
      // single mode bit: polarity picks the edge direction
      assign evt = cfg_q.mode[0] ? (cfg_q.pol ? rise : fall) : lvl;
      always_comb begin
        cfg_d         = cfg_wdata_i;
        cfg_d.mode[1] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q    <= 1'b0;
      cfg_q    <= '0;
      status_q <= 1'b0;
    end else begin
      pin_q    <= pin_i;
      if (cfg_we_i) cfg_q <= cfg_d;
      // set beats clear
      status_q <= (cfg_q.raw_en & evt) | (status_q & ~ack_i);
    end
  end

  assign cfg_o    = cfg_q;
  assign status_o = status_q;
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] stat_i,
  input  logic [NUM_PINS-1:0] en_i,
  input  logic [TGT_W-1:0]    tgt_i [NUM_PINS],
  output logic [NUM_TGT-1:0]  irq_o
);
  logic [NUM_TGT-1:0] hit, irq_q;

  always_comb begin
    hit = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (stat_i[p] && en_i[p]) hit[tgt_i[p]] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= hit;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int  NUM_PINS = 8,
  parameter int  DET_W    = 2,
  parameter bit  ACK_VAL  = 1'b1,
  localparam int SEL_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W   = SEL_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CFG_W-1:0]    wdata_i,
  output logic [CFG_W-1:0]    rdata_o,
  output logic [NUM_TGT-1:0]  irq_o
);
  localparam int SLOTS = 1 << SEL_W;

  logic [SEL_W-1:0]          sel;
  logic                      is_stat, ack_hit;
  cfg_t                      cfg_v [NUM_PINS];
  logic [NUM_PINS-1:0]       status_q, en_v;
  logic [TGT_W-1:0]          tgt_v [NUM_PINS];
  logic [NUM_PINS*CFG_W-1:0] cfg_flat;
  logic [CFG_W-1:0]          rd_cfg [SLOTS];
  logic [SLOTS-1:0]          rd_st, rd_pin;

  assign sel     = addr_i[ADDR_W-1:1];
  assign is_stat = addr_i[0];
  assign ack_hit = we_i & is_stat & (wdata_i[0] == ACK_VAL);

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic pick;
      assign pick = (sel == SEL_W'(p));

      gpio_irq_pin #(.DET_W(DET_W)) u_pin (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pin_i      (pin_i[p]),
        .cfg_we_i   (we_i & ~is_stat & pick),
        .cfg_wdata_i(cfg_t'(wdata_i)),
        .ack_i      (ack_hit & pick),
        .cfg_o      (cfg_v[p]),
        .status_o   (status_q[p])
      );

      assign en_v[p]                      = cfg_v[p].en;
      assign tgt_v[p]                     = cfg_v[p].target;
      assign cfg_flat[p*CFG_W +: CFG_W]   = cfg_v[p];
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (s < NUM_PINS) begin : g_used
        assign rd_cfg[s] = cfg_v[s];
        assign rd_st[s]  = status_q[s];
        assign rd_pin[s] = pin_i[s];
      end else begin : g_empty
        assign rd_cfg[s] = '0;
        assign rd_st[s]  = 1'b0;
        assign rd_pin[s] = 1'b0;
      end
    end
  endgenerate

  assign rdata_o = is_stat ? {{(CFG_W-2){1'b0}}, rd_pin[sel], rd_st[sel]} : rd_cfg[sel];

  gpio_irq_route #(.NUM_PINS(NUM_PINS)) u_route (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stat_i(status_q),
    .en_i  (en_v),
    .tgt_i (tgt_v),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DET_W    = 2,
  parameter bit ACK_VAL  = 1'b1,
  parameter int SEL_W    = 3
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_PINS-1:0]       pin_i,
  input logic                      we_i,
  input logic [SEL_W:0]            addr_i,
  input logic                      ack_bit_i,
  input logic [NUM_TGT-1:0]        irq_o,
  input logic [NUM_PINS-1:0]       status_q,
  input logic [NUM_PINS*CFG_W-1:0] cfg_flat
);
  logic [NUM_TGT-1:0] want;

  always_comb begin
    want = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (status_q[p] && cfg_flat[p*CFG_W]) want[cfg_flat[p*CFG_W+5 +: TGT_W]] = 1'b1;
    end
  end

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_p
      cfg_t c;
      logic ack_p, lvl_mode;
      assign c        = cfg_t'(cfg_flat[p*CFG_W +: CFG_W]);
      assign ack_p    = we_i && addr_i[0] && (addr_i[SEL_W:1] == SEL_W'(p)) && (ack_bit_i == ACK_VAL);
      assign lvl_mode = (DET_W == 2) ? (c.mode == 2'd0) : !c.mode[0];

      AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_q[p] && !ack_p |=> status_q[p]); // R6
      AST_RAW_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !c.raw_en && !status_q[p] |=> !status_q[p]); // R8
      AST_LEVEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c.raw_en && lvl_mode && (pin_i[p] == c.pol) |=> status_q[p]); // R3
      if (DET_W == 2) begin : g_rise
        AST_RISE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
          c.raw_en && (c.mode == 2'd1) && pin_i[p] && !$past(pin_i[p]) |=> status_q[p]); // R4
      end
    end

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_t
      AST_IRQ_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        want[t] |=> irq_o[t]); // R10
      AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !want[t] |=> !irq_o[t]); // R9
    end
  endgenerate
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
  .NUM_PINS(NUM_PINS), .DET_W(DET_W), .ACK_VAL(ACK_VAL), .SEL_W(SEL_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pin_i    (pin_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .ack_bit_i(wdata_i[0]),
  .irq_o    (irq_o),
  .status_q (status_q),
  .cfg_flat (cfg_flat)
);

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
module gpio_irq_detect_tb;
  localparam int NP = 8;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP-1:0] pin = '0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0, rdata, irq;

  logic [NP-1:0] n_pin = '0;
  logic          n_we = 1'b0;
  logic [AW-1:0] n_addr = '0;
  logic [7:0]    n_wdata = '0, n_rdata, n_irq;

  gpio_irq_detect #(.NUM_PINS(NP), .DET_W(2), .ACK_VAL(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  gpio_irq_detect #(.NUM_PINS(NP), .DET_W(1), .ACK_VAL(1'b1)) u_dut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(n_pin), .we_i(n_we), .addr_i(n_addr),
    .wdata_i(n_wdata), .rdata_o(n_rdata), .irq_o(n_irq));

  int checks = 0, errors = 0;
  bit done = 0;
  bit [7:0] m_cfg [NP];
  bit       m_st  [NP];
  bit       m_pq  [NP];
  bit [7:0] m_irq;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit evt(bit [7:0] c, bit p, bit q);
    case (c[2:1])
      2'd0:    return p == c[3];
      2'd1:    return p & !q;
      2'd2:    return !p & q;
      default: return p != q;
    endcase
  endfunction

  function automatic bit [3:0] ca(int p); return {p[2:0], 1'b0}; endfunction
  function automatic bit [3:0] sa(int p); return {p[2:0], 1'b1}; endfunction

  task automatic step();
    bit [7:0] nc [NP];
    bit       ns [NP];
    bit [7:0] ni = '0;
    for (int p = 0; p < NP; p++) begin
      bit ack = we && addr[0] && (addr[3:1] == p[2:0]) && wdata[0];
      nc[p] = m_cfg[p];
      if (we && !addr[0] && (addr[3:1] == p[2:0])) nc[p] = wdata;
      ns[p] = (m_cfg[p][4] && evt(m_cfg[p], pin[p], m_pq[p])) || (m_st[p] && !ack);
      if (m_st[p] && m_cfg[p][0]) ni[m_cfg[p][7:5]] = 1'b1;
    end
    @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      m_cfg[p] = nc[p]; m_st[p] = ns[p]; m_pq[p] = pin[p];
    end
    m_irq = ni;
    @(negedge clk);
    chk(irq == m_irq, "R10 summary vs model", irq, m_irq);
  endtask

  task automatic wr(bit [3:0] a, bit [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(bit [3:0] a, bit [7:0] exp, string tag);
    addr = a; #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic stat(int p, bit exp, string tag);
    rd(sa(p), {6'b0, pin[p], exp}, tag);
  endtask

  task automatic nwr(bit [3:0] a, bit [7:0] d);
    n_we = 1'b1; n_addr = a; n_wdata = d;
    step();
    n_we = 1'b0;
  endtask

  task automatic nrd(bit [3:0] a, bit [7:0] exp, string tag);
    n_addr = a; #1;
    chk(n_rdata == exp, tag, n_rdata, exp);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int p = 0; p < NP; p++) begin m_cfg[p] = '0; m_st[p] = 0; m_pq[p] = 0; end
    m_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(irq == 8'h00, "R1 irq after reset", irq, 0);
    rd(ca(3), 8'h00, "R1 cfg after reset");
    stat(3, 0, "R1 status after reset");

    // R2 config write/read: en, rise, pol, raw, target 2
    wr(ca(1), 8'h5B);
    rd(ca(1), 8'h5B, "R2 cfg readback");
    // R4 rising edge, R10 summary one clock later
    pin[1] = 1'b1; step();
    stat(1, 1, "R4 rise sets status");
    chk(irq[2] == 1'b0, "R10 irq not yet", irq[2], 0);
    step();
    chk(irq[2] == 1'b1, "R10 irq raised", irq[2], 1);
    // R6 acknowledge value
    wr(sa(1), 8'h00);
    stat(1, 1, "R6 wrong ack ignored");
    wr(sa(1), 8'h01);
    stat(1, 0, "R6 ack clears");
    // R4 falling edge ignored in rise mode; R7 event beats ack
    pin[1] = 1'b0; step();
    stat(1, 0, "R4 fall ignored in rise mode");
    pin[1] = 1'b1; wr(sa(1), 8'h01);
    stat(1, 1, "R7 event wins over ack");
    // R9 masked pin still latches
    wr(ca(1), 8'h5A);
    wr(sa(1), 8'h01);
    pin[1] = 1'b0; step();
    pin[1] = 1'b1; step();
    stat(1, 1, "R9 masked still latches");
    step(); step();
    chk(irq[2] == 1'b0, "R9 masked no irq", irq[2], 0);
    // R8 latch enable gate and no edge from enabling it
    wr(ca(1), 8'h4B);
    wr(sa(1), 8'h01);
    pin[1] = 1'b0; step();
    pin[1] = 1'b1; step();
    stat(1, 0, "R8 raw off blocks");
    wr(ca(1), 8'h5B);
    step(); step();
    stat(1, 0, "R8 raw enable no edge");
    // R3 level high, R7 ack under active level
    wr(ca(2), 8'hB9);
    step();
    stat(2, 0, "R3 level inactive");
    pin[2] = 1'b1; step();
    stat(2, 1, "R3 level high sets");
    wr(sa(2), 8'h01);
    stat(2, 1, "R7 ack while level active");
    pin[2] = 1'b0; step();
    stat(2, 1, "R6 sticky after level drop");
    wr(sa(2), 8'h01);
    stat(2, 0, "R6 ack after level drop");
    wr(ca(2), 8'hB1);
    step();
    stat(2, 1, "R3 level low sets");
    // R4 falling and both
    wr(ca(3), 8'h14);
    pin[3] = 1'b1; step();
    stat(3, 0, "R4 rise ignored in fall mode");
    pin[3] = 1'b0; step();
    stat(3, 1, "R4 fall sets");
    wr(ca(3), 8'h16);
    wr(sa(3), 8'h01);
    pin[3] = 1'b1; step();
    stat(3, 1, "R4 both-edge rise sets");
    // R11 live pin in status read
    pin[4] = 1'b1;
    rd(sa(4), 8'h02, "R11 pin bit");

    // R5 narrow mode option
    nwr(ca(0), 8'h17);
    nrd(ca(0), 8'h13, "R5 upper mode bit reads 0");
    n_pin[0] = 1'b1; step();
    nrd(sa(0), 8'h02, "R5 rise ignored when pol 0");
    n_pin[0] = 1'b0; step();
    nrd(sa(0), 8'h01, "R5 fall sets when pol 0");
    nwr(ca(1), 8'h18);
    n_pin[1] = 1'b1; step();
    nrd(sa(1), 8'h03, "R5 level high sets");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int p = $urandom % NP;
      if ($urandom % 4 == 0) rd(ca(p), m_cfg[p], "R2 random cfg readback");
      else                   stat(p, m_st[p], "R11 random status read");
      if ($urandom % 3 == 0) pin = pin ^ 8'($urandom);
      if ($urandom % 3 == 0) begin
        we = 1'b1; addr = 4'($urandom); wdata = 8'($urandom);
      end
      step();
      we = 1'b0;
    end

    done = 1;
    summary();
    $finish;
  end
endmodule